// File: doc/BRIEF.md
# Execute-Stage Arithmetic and Logic Unit

This unit is the arithmetic and logic engine of the execute stage in a small five-stage pipelined processor with eight general registers. Decode hands it a 2-bit instruction category, a 4-bit function code, an immediate-select bit and three 16-bit operand values. The operands are two register values and one immediate. Within the same cycle, the unit returns a primary result, a secondary result and two write-back enables. The secondary result is used only by the register exchange.

The zero, negative and carry flags are held in registers inside the unit. They take their new values on the clock edge that ends the operation. The carry flag also feeds the two rotate-through-carry operations.

The unit does nothing unless two conditions hold together: the category is the arithmetic one, and the immediate-select bit matches the function code. Any other combination behaves as a no-operation. Register addressing, hazards, memory, ports and jumps all belong to neighbouring pipeline logic.

Top module: `exec_alu`

## Requirements
- R1: The unit is enabled only when `cat_i` is 2'b00 and `imm_sel_i` equals 1 for codes 0101, 1011, 1100, 1101 and 1111, or equals 0 for every other code. When it is not enabled, both results read zero, both write-back enables are low, and all three flags keep their values. This covers the all-ones no-operation in category 2'b11.
- R2: Codes 0001 (negate), 0010 (increment), 0011 (decrement), 0100 (add), 0101 (add immediate) and 0110 (subtract) produce results modulo 2^16. Carry is the carry out for increment and both adds. Carry is the borrow for negate (set when the operand is non-zero), for decrement (set when the operand is zero) and for subtract (set when A < B unsigned).
- R3: Codes 0000 (invert A), 0111 (A and B), 1000 (A xor B) and 1001 (A or B) give the bitwise result and leave carry unchanged.
- R4: For every enabled code except 1110 and 1111, the zero flag after the clock edge is 1 exactly when the result was all zeros. The negative flag is the result's bit 15. Flags read 0 after reset.
- R5: Code 1010 (compare) shows A − B on `res_o` and sets the flags exactly as subtract does, but raises no write-back enable.
- R6: Code 1011 sets bit `imm_i[3:0]` of A. Carry becomes that bit's previous value.
- R7: Code 1100 gives {carry, A[15:1]}. The new carry is A[0].
- R8: Code 1101 gives {A[14:0], carry}. The new carry is A[15].
- R9: Code 1110 puts B on `res_o` and A on `res2_o`, raises both write-back enables, and leaves all flags unchanged.
- R10: Code 1111 passes `imm_i` unchanged to `res_o`, raises the first write-back enable, and leaves all flags unchanged.
- R11: When enabled, `wb1_en_o` is high for every code except 1010. `wb2_en_o` is high only for 1110. `res2_o` is zero except during 1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for the flags |
| cat_i | input | 2 | Instruction category; 2'b00 selects this unit |
| imm_sel_i | input | 1 | Immediate-select bit from decode |
| func_i | input | 4 | Function code |
| opa_i | input | 16 | First register operand |
| opb_i | input | 16 | Second register operand |
| imm_i | input | 16 | Immediate operand |
| res_o | output | 16 | Primary result |
| res2_o | output | 16 | Secondary result (exchange only) |
| wb1_en_o | output | 1 | Write-back enable, first destination |
| wb2_en_o | output | 1 | Write-back enable, second destination |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The only internal state is the three flags. A flag that was updated wrongly, or that failed to hold, shows up in two places. It appears directly on the flag ports one cycle after the faulty operation. It also appears on `res_o` at the next rotate, which shifts the stale carry into bit 15 or bit 0.

The bench keeps its own flag model and compares all three flags before every operation. A corrupted flag is therefore reported no later than the following operation. Each function code is swept across a set of edge-value operands, with the carry entering from many different preceding operations.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;

   localparam logic [1:0] CAT_ARITH = 2'b00;

   typedef enum logic [3:0] {
      FN_NOT    = 4'h0,
      FN_NEG    = 4'h1,
      FN_INC    = 4'h2,
      FN_DEC    = 4'h3,
      FN_ADD    = 4'h4,
      FN_ADDI   = 4'h5,
      FN_SUB    = 4'h6,
      FN_AND    = 4'h7,
      FN_XOR    = 4'h8,
      FN_OR     = 4'h9,
      FN_CMP    = 4'hA,
      FN_BITSET = 4'hB,
      FN_RCR    = 4'hC,
      FN_RCL    = 4'hD,
      FN_SWAP   = 4'hE,
      FN_LDM    = 4'hF
   } alu_fn_e;

   // Codes whose encoding demands the immediate-select bit high.
   function automatic logic fn_wants_imm(alu_fn_e f);
      return f inside {FN_ADDI, FN_BITSET, FN_RCR, FN_RCL, FN_LDM};
   endfunction

   function automatic logic fn_updates_zn(alu_fn_e f);
      return !(f inside {FN_SWAP, FN_LDM});
   endfunction

   function automatic logic fn_updates_c(alu_fn_e f);
      return f inside {FN_NEG, FN_INC, FN_DEC, FN_ADD, FN_ADDI, FN_SUB,
                       FN_CMP, FN_BITSET, FN_RCR, FN_RCL};
   endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
   import exec_alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_fn_e           fn_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [DATA_W-1:0] imm_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] res_o,
   output logic [DATA_W-1:0] swap_o,
   output logic              c_o
);
   localparam int IDX_W = $clog2(DATA_W);

   logic [DATA_W-1:0] bit_mask;
   logic [DATA_W:0]   ext;
   logic [IDX_W-1:0]  bit_idx;

   assign bit_idx = imm_i[IDX_W-1:0];

   // One-hot decode of the bit position for the single-bit set.
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
      assign bit_mask[gi] = (bit_idx == IDX_W'(gi));
   end

   assign swap_o = opa_i;

   always_comb begin
      res_o = '0;
      c_o   = c_i;
      ext   = '0;
      unique case (fn_i)
         FN_NOT: res_o = ~opa_i;
         FN_NEG: begin
            ext   = {(DATA_W+1){1'b0}} - {1'b0, opa_i};
            res_o = ext[DATA_W-1:0];
            c_o   = ext[DATA_W];
         end
         FN_INC: begin
            ext   = {1'b0, opa_i} + {{DATA_W{1'b0}}, 1'b1};
            res_o = ext[DATA_W-1:0];
            c_o   = ext[DATA_W];
         end
         FN_DEC: begin
            ext   = {1'b0, opa_i} - {{DATA_W{1'b0}}, 1'b1};
            res_o = ext[DATA_W-1:0];
            c_o   = ext[DATA_W];
         end
         FN_ADD: begin
            ext   = {1'b0, opa_i} + {1'b0, opb_i};
            res_o = ext[DATA_W-1:0];
            c_o   = ext[DATA_W];
         end
         FN_ADDI: begin
            ext   = {1'b0, opa_i} + {1'b0, imm_i};
            res_o = ext[DATA_W-1:0];
            c_o   = ext[DATA_W];
         end
         FN_SUB, FN_CMP: begin
            ext   = {1'b0, opa_i} - {1'b0, opb_i};
            res_o = ext[DATA_W-1:0];
            c_o   = ext[DATA_W];
         end
         FN_AND: res_o = opa_i & opb_i;
         FN_XOR: res_o = opa_i ^ opb_i;
         FN_OR:  res_o = opa_i | opb_i;
         FN_BITSET: begin
            res_o = opa_i | bit_mask;
            c_o   = |(opa_i & bit_mask);
         end
         FN_RCR: begin
            res_o = {c_i, opa_i[DATA_W-1:1]};
            c_o   = opa_i[0];
         end
         FN_RCL: begin
            res_o = {opa_i[DATA_W-2:0], c_i};
            c_o   = opa_i[DATA_W-1];
         end
         FN_SWAP: res_o = opb_i;
         FN_LDM:  res_o = imm_i;
         default: res_o = '0;
      endcase
   end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_zn_i,
   input  logic              upd_c_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              c_i,
   output logic              z_o,
   output logic              n_o,
   output logic              c_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z_o <= 1'b0;
         n_o <= 1'b0;
         c_o <= 1'b0;
      end else begin
         if (upd_zn_i) begin
            z_o <= (res_i == '0);
            n_o <= res_i[DATA_W-1];
         end
         if (upd_c_i) c_o <= c_i;
      end
   end
endmodule

// File: rtl/alu_wb_ctrl.sv
module alu_wb_ctrl
   import exec_alu_pkg::*;
(
   input  logic    en_i,
   input  alu_fn_e fn_i,
   output logic    wb1_o,
   output logic    wb2_o
);
   assign wb1_o = en_i && (fn_i != FN_CMP);
   assign wb2_o = en_i && (fn_i == FN_SWAP);
endmodule

// File: rtl/exec_alu.sv
module exec_alu
   import exec_alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cat_i,
   input  logic              imm_sel_i,
   input  logic [3:0]        func_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [DATA_W-1:0] imm_i,
   output logic [DATA_W-1:0] res_o,
   output logic [DATA_W-1:0] res2_o,
   output logic              wb1_en_o,
   output logic              wb2_en_o,
   output logic              flag_z_o,
   output logic              flag_n_o,
   output logic              flag_c_o
);
   if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("exec_alu: DATA_W must be a power of two of at least 4");
   end

   alu_fn_e           fn;
   logic              en;
   logic [DATA_W-1:0] dp_res;
   logic [DATA_W-1:0] dp_swap;
   logic              dp_c;

   assign fn = alu_fn_e'(func_i);
   assign en = (cat_i == CAT_ARITH) && (imm_sel_i == fn_wants_imm(fn));

   alu_datapath #(.DATA_W(DATA_W)) u_dp (
      .fn_i   (fn),
      .opa_i  (opa_i),
      .opb_i  (opb_i),
      .imm_i  (imm_i),
      .c_i    (flag_c_o),
      .res_o  (dp_res),
      .swap_o (dp_swap),
      .c_o    (dp_c)
   );

   alu_wb_ctrl u_wb (
      .en_i  (en),
      .fn_i  (fn),
      .wb1_o (wb1_en_o),
      .wb2_o (wb2_en_o)
   );

   alu_flag_reg #(.DATA_W(DATA_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_zn_i (en && fn_updates_zn(fn)),
      .upd_c_i  (en && fn_updates_c(fn)),
      .res_i    (dp_res),
      .c_i      (dp_c),
      .z_o      (flag_z_o),
      .n_o      (flag_n_o),
      .c_o      (flag_c_o)
   );

   assign res_o  = en ? dp_res : '0;
   assign res2_o = wb2_en_o ? dp_swap : '0;

   // R1: an idle cycle leaves every flag untouched
   a_r1_idle_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable({flag_z_o, flag_n_o, flag_c_o}));

   // R4: zero and negative flags reflect the previous result
   a_r4_zero_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (en && fn_updates_zn(fn)) |=> (flag_z_o == ($past(res_o) == '0)));
   a_r4_neg_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (en && fn_updates_zn(fn)) |=> (flag_n_o == $past(res_o[DATA_W-1])));

   // R5: compare never writes a register
   a_r5_cmp_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (en && fn == FN_CMP) |-> (!wb1_en_o && !wb2_en_o));

   // R7 / R8: rotate carries out the bit that leaves the word
   a_r7_rcr_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (en && fn == FN_RCR) |=> (flag_c_o == $past(opa_i[0])));
   a_r8_rcl_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (en && fn == FN_RCL) |=> (flag_c_o == $past(opa_i[DATA_W-1])));

   // R9 / R11: second write only with exchange, always paired with the first
   a_r11_wb2_only_swap: assert property (@(posedge clk) disable iff (!rst_n)
      wb2_en_o |-> (wb1_en_o && fn == FN_SWAP && cat_i == CAT_ARITH));
   // R9: exchange leaves flags unchanged
   a_r9_swap_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (en && fn == FN_SWAP) |=> $stable({flag_z_o, flag_n_o, flag_c_o}));
endmodule

// File: tb/exec_alu_tb.sv
module exec_alu_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cat = 2'b11;
   logic        isel = 1'b1;
   logic [3:0]  fn = 4'hF;
   logic [15:0] a = '0, b = '0, im = '0;
   logic [15:0] res, res2;
   logic        wb1, wb2, fz, fn_flag, fc;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench flag model
   logic m_z = 1'b0, m_n = 1'b0, m_c = 1'b0;
   string prev_tag = "R4";

   always #(CLK_PERIOD/2) clk = ~clk;

   exec_alu dut_i (
      .clk(clk), .rst_n(rst_n), .cat_i(cat), .imm_sel_i(isel), .func_i(fn),
      .opa_i(a), .opb_i(b), .imm_i(im), .res_o(res), .res2_o(res2),
      .wb1_en_o(wb1), .wb2_en_o(wb2), .flag_z_o(fz), .flag_n_o(fn_flag),
      .flag_c_o(fc)
   );

   function automatic bit wants_imm(logic [3:0] f);
      return f == 4'h5 || f == 4'hB || f == 4'hC || f == 4'hD || f == 4'hF;
   endfunction

   task automatic check(input string tag, input logic [63:0] got,
                        input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic check_flags();
      check({prev_tag, " flags"}, {61'd0, fz, fn_flag, fc},
            {61'd0, m_z, m_n, m_c});
   endtask

   task automatic run_op(input logic [1:0] c_in, input logic s_in,
                         input logic [3:0] f, input logic [15:0] xa,
                         input logic [15:0] xb, input logic [15:0] xi);
      logic        on, e_wb1, e_wb2, upd_zn, upd_c, nc;
      logic [15:0] r, r2;
      logic [16:0] w;
      string       tag;
      on = (c_in == 2'b00) && (s_in == wants_imm(f));
      r = '0; r2 = '0; nc = m_c; upd_zn = 1'b1; upd_c = 1'b0; tag = "R1";
      case (f)
         4'h0: begin r = ~xa; tag = "R3"; end
         4'h1: begin r = 16'(17'd0 - 17'(xa)); nc = (xa != 0); upd_c = 1; tag = "R2"; end
         4'h2: begin r = xa + 16'd1; nc = (xa == 16'hFFFF); upd_c = 1; tag = "R2"; end
         4'h3: begin r = xa - 16'd1; nc = (xa == 16'h0000); upd_c = 1; tag = "R2"; end
         4'h4: begin w = 17'(xa) + 17'(xb); r = w[15:0]; nc = w[16]; upd_c = 1; tag = "R2"; end
         4'h5: begin w = 17'(xa) + 17'(xi); r = w[15:0]; nc = w[16]; upd_c = 1; tag = "R2"; end
         4'h6: begin r = xa - xb; nc = (xa < xb); upd_c = 1; tag = "R2"; end
         4'h7: begin r = xa & xb; tag = "R3"; end
         4'h8: begin r = xa ^ xb; tag = "R3"; end
         4'h9: begin r = xa | xb; tag = "R3"; end
         4'hA: begin r = xa - xb; nc = (xa < xb); upd_c = 1; tag = "R5"; end
         4'hB: begin r = xa | (16'd1 << xi[3:0]); nc = xa[xi[3:0]]; upd_c = 1; tag = "R6"; end
         4'hC: begin r = (xa >> 1) | (m_c ? 16'h8000 : 16'h0000); nc = xa[0]; upd_c = 1; tag = "R7"; end
         4'hD: begin r = (xa << 1) | {15'd0, m_c}; nc = xa[15]; upd_c = 1; tag = "R8"; end
         4'hE: begin r = xb; r2 = xa; upd_zn = 0; tag = "R9"; end
         default: begin r = xi; upd_zn = 0; tag = "R10"; end
      endcase
      e_wb1 = on && (f != 4'hA);
      e_wb2 = on && (f == 4'hE);
      if (!on) begin r = '0; r2 = '0; tag = "R1"; end
      @(negedge clk);
      check_flags();
      cat = c_in; isel = s_in; fn = f; a = xa; b = xb; im = xi;
      #1;
      check({tag, " result"}, {32'd0, res, res2}, {32'd0, r, r2});
      check("R11 write-back enables", {62'd0, wb1, wb2}, {62'd0, e_wb1, e_wb2});
      if (on) begin
         if (upd_zn) begin m_z = (r == 16'h0); m_n = r[15]; end
         if (upd_c) m_c = nc;
      end
      prev_tag = on ? ((upd_zn || upd_c) ? "R4" : tag) : "R1";
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] pat [7];
      pat = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5A5, 16'h1234};
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R4 reset state of the flags, R1 idle outputs
      check("R4 reset flags", {61'd0, fz, fn_flag, fc}, 64'd0);
      check("R1 idle outputs", {30'd0, res, res2, wb1, wb2}, 64'd0);
      rst_n = 1'b1;
      // Full sweep of every function over edge-value operands
      for (int f = 0; f < 16; f++)
         for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++)
               run_op(2'b00, wants_imm(4'(f)), 4'(f), pat[i], pat[j],
                      pat[j] + 16'(j * 3));
      // R1 mismatched immediate-select bit is ignored
      for (int f = 0; f < 16; f++) begin
         run_op(2'b00, 1'b0, 4'hA, 16'h0003, 16'h0005, 16'h0);
         run_op(2'b00, !wants_imm(4'(f)), 4'(f), 16'h0000, 16'h0000, 16'h0);
      end
      // R1 other categories and the all-ones no-operation
      for (int c = 1; c < 4; c++)
         for (int f = 0; f < 16; f++)
            run_op(2'(c), wants_imm(4'(f)), 4'(f), 16'h8000, 16'h8000, 16'hFFFF);
      run_op(2'b11, 1'b1, 4'hF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
      // R7 R8 rotate chains carry through successive operations
      for (int k = 0; k < 20; k++) begin
         run_op(2'b00, 1'b1, 4'hC, 16'h0001 + 16'(k), 16'h0, 16'h0);
         run_op(2'b00, 1'b1, 4'hD, 16'h8000 ^ 16'(k), 16'h0, 16'h0);
      end
      // R6 every bit position
      for (int k = 0; k < 16; k++)
         run_op(2'b00, 1'b1, 4'hB, 16'h5555, 16'h0, 16'(k));
      @(negedge clk);
      check_flags();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule